// File: doc/BRIEF.md
# Serial Slave Byte-Memory Access Port

This block lets an external serial host read and write an internal byte-addressed memory through a four-wire serial link. It uses SPI mode 0 with an active-low select. Every frame opens with a 16-bit address from the host. An 8-bit command follows, and its top bit selects read or write. The slave then shifts out one status byte, and any number of data bytes follow. During a burst the memory address steps up by one per data byte until the host releases select. On a read burst the slave fetches the next byte ahead of time, so it is ready at each byte boundary.

The block runs on a fast system clock. The serial clock, select and data input arrive already synchronous to that clock, and the block finds their edges by comparing them with their value one cycle earlier. The memory side is a simple synchronous byte port with one cycle of read latency. The block only enables the output line while it has status or read data to send; the pad tristate sits outside the block. When the host releases select after a complete command, the block copies the command into a holding register and raises a one-cycle interrupt. It does neither for the two idle command codes.

Top module: `smap_top`

## Requirements
- R1: Serial bit slots 0 to 15 carry the address, most significant bit first, sampled on rising serial clock edges; only the low ADDR_W bits are kept.
- R2: Slots 16 to 23 carry the command, most significant bit first; command bit 7 = 1 selects read, 0 selects write.
- R3: In slots 24 to 31 the slave drives status_in, most significant bit first; status_in is captured at the falling serial edge that opens slot 24.
- R4: On a read, slots from 32 on carry memory bytes starting at the frame address, most significant bit first; each output bit changes on a falling edge; the address steps by one per byte and wraps modulo 2^ADDR_W.
- R5: On a write, each complete data byte from slot 32 on is written to memory at the frame address plus its byte index (modulo 2^ADDR_W).
- R6: spi_miso_oe is 1 only in slots 24 to 31 and, for reads, in data slots; it is 0 while spi_csn is high.
- R7: When spi_csn rises after all 24 address and command bits were received, cmd_reg takes the command and irq is high for exactly one clock.
- R8: If the command is exactly 0x80 or 0x00, cmd_reg keeps its value and irq stays low; a 0x00 write still writes its data.
- R9: Raising spi_csn at any point aborts the frame. A partial data byte is never written, and a frame cut off before slot 24 changes neither cmd_reg nor irq.
- R10: mem_re and mem_we are single-cycle strobes that are never both high, and mem_rdata is expected one clock after mem_re.
- R11: After reset, irq, mem_we, mem_re and spi_miso_oe are 0 and cmd_reg is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_csn | input | 1 | Select from host, active low |
| spi_sclk | input | 1 | Serial clock from host, idle low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| spi_miso_oe | output | 1 | Output enable for the spi_miso pad |
| status_in | input | 8 | Status byte returned in slots 24 to 31 |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_rdata | input | 8 | Memory read data, one cycle after mem_re |
| cmd_reg | output | 8 | Last completed command |
| irq | output | 1 | One-cycle end-of-frame interrupt |

## Verification
The bench builds the block with ADDR_W = 8, so a 256-byte behavioural memory covers the whole address space. Frames that start at 0xFE or 0xFF then carry both read and write bursts across the wrap to 0x00. Because the bench sends addresses with non-zero upper bits, it also shows that those bits are dropped. A serial half-period of four system clocks leaves room for the read prefetch before slot 32. Partial frames are cut in the command, in the status byte and in the middle of a data byte.

// File: rtl/smap_pkg.sv
package smap_pkg;
  localparam int CNT_W       = 6;
  localparam int BYTE_W      = 8;
  localparam int FRAME_ADR_W = 16;
  localparam logic [CNT_W-1:0] SLOT_CMD  = 6'd16;
  localparam logic [CNT_W-1:0] SLOT_CEND = 6'd23;
  localparam logic [CNT_W-1:0] SLOT_STAT = 6'd24;
  localparam logic [CNT_W-1:0] SLOT_DATA = 6'd32;
  localparam logic [CNT_W-1:0] SLOT_LAST = 6'd39;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/smap_rst_sync.sv
module smap_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_no = stage_q[1];
endmodule

// File: rtl/smap_edge.sv
module smap_edge (
  input  logic clk,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic csn_i,
  output logic sclk_rise_o,
  output logic sclk_fall_o,
  output logic cs_end_o
);
  logic sclk_q, csn_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      csn_q  <= 1'b1;
    end else begin
      sclk_q <= sclk_i;
      csn_q  <= csn_i;
    end
  end

  assign sclk_rise_o = !csn_i &&  sclk_i && !sclk_q;
  assign sclk_fall_o = !csn_i && !sclk_i &&  sclk_q;
  assign cs_end_o    =  csn_i && !csn_q;
endmodule

// File: rtl/smap_frame.sv
module smap_frame
  import smap_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             csn_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             mosi_i,
  input  byte_t            mem_rdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output byte_t            cmd_o,
  output logic             cmd_done_o,
  output byte_t            rbuf_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output byte_t            mem_wdata_o,
  output logic             mem_we_o,
  output logic             mem_re_o
);
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d, maddr_q, maddr_d;
  byte_t             cmd_q, cmd_d, sh_q, sh_d, wd_q, wd_d, rbuf_q, rbuf_d;
  logic              done_q, done_d, we_q, we_d, re_q, re_d, pend_q;
  logic              is_read;

  assign is_read = cmd_q[BYTE_W-1];

  always_comb begin
    cnt_d   = cnt_q;
    ptr_d   = ptr_q;
    cmd_d   = cmd_q;
    sh_d    = sh_q;
    done_d  = done_q;
    wd_d    = wd_q;
    maddr_d = maddr_q;
    we_d    = 1'b0;
    re_d    = 1'b0;
    rbuf_d  = pend_q ? mem_rdata_i : rbuf_q;
    if (csn_i) begin
      cnt_d  = '0;
      done_d = 1'b0;
    end else if (rise_i) begin
      cnt_d = (cnt_q == SLOT_LAST) ? SLOT_DATA : cnt_q + 1'b1;
      sh_d  = {sh_q[BYTE_W-2:0], mosi_i};
      if (cnt_q < SLOT_CMD) begin
        ptr_d = {ptr_q[ADDR_W-2:0], mosi_i};
      end else if (cnt_q <= SLOT_CEND) begin
        cmd_d = {cmd_q[BYTE_W-2:0], mosi_i};
        if (cnt_q == SLOT_CEND) done_d = 1'b1;
      end
      if (done_q && is_read && (cnt_q == SLOT_STAT || cnt_q == SLOT_DATA)) begin
        re_d    = 1'b1;
        maddr_d = ptr_q;
      end
      if (done_q && !is_read && cnt_q == SLOT_LAST) begin
        we_d    = 1'b1;
        maddr_d = ptr_q;
        wd_d    = {sh_q[BYTE_W-2:0], mosi_i};
        ptr_d   = ptr_q + 1'b1;
      end
    end else if (fall_i && done_q && is_read && cnt_q == SLOT_DATA) begin
      ptr_d = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      ptr_q   <= '0;
      cmd_q   <= '0;
      sh_q    <= '0;
      done_q  <= 1'b0;
      wd_q    <= '0;
      maddr_q <= '0;
      we_q    <= 1'b0;
      re_q    <= 1'b0;
      pend_q  <= 1'b0;
      rbuf_q  <= '0;
    end else begin
      cnt_q   <= cnt_d;
      ptr_q   <= ptr_d;
      cmd_q   <= cmd_d;
      sh_q    <= sh_d;
      done_q  <= done_d;
      wd_q    <= wd_d;
      maddr_q <= maddr_d;
      we_q    <= we_d;
      re_q    <= re_d;
      pend_q  <= re_q;
      rbuf_q  <= rbuf_d;
    end
  end

  assign cnt_o       = cnt_q;
  assign cmd_o       = cmd_q;
  assign cmd_done_o  = done_q;
  assign rbuf_o      = rbuf_q;
  assign mem_addr_o  = maddr_q;
  assign mem_wdata_o = wd_q;
  assign mem_we_o    = we_q;
  assign mem_re_o    = re_q;

  a_r10_strobe_excl: assert property (@(posedge clk) disable iff (!rst_ni)
    !(we_q && re_q));
  a_r5_we_write_cmd: assert property (@(posedge clk) disable iff (!rst_ni)
    we_q |-> !cmd_q[BYTE_W-1]);
  a_r4_re_read_cmd: assert property (@(posedge clk) disable iff (!rst_ni)
    re_q |-> cmd_q[BYTE_W-1]);
  a_r10_we_single: assert property (@(posedge clk) disable iff (!rst_ni)
    we_q |=> !we_q);
  a_r9_cnt_cleared: assert property (@(posedge clk) disable iff (!rst_ni)
    csn_i |=> (cnt_q == '0 && !done_q));
  a_r4_cnt_range: assert property (@(posedge clk) disable iff (!rst_ni)
    cnt_q <= SLOT_LAST);
endmodule

// File: rtl/smap_tx.sv
module smap_tx
  import smap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             csn_i,
  input  logic             fall_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             is_read_i,
  input  byte_t            status_i,
  input  byte_t            rbuf_i,
  output logic             miso_o,
  output logic             oe_o
);
  byte_t tx_q, tx_d;
  logic  oe_q, oe_d;

  always_comb begin
    tx_d = tx_q;
    oe_d = oe_q;
    if (csn_i) begin
      oe_d = 1'b0;
    end else if (fall_i) begin
      if (cnt_i == SLOT_STAT) begin
        tx_d = status_i;
        oe_d = 1'b1;
      end else if (cnt_i == SLOT_DATA) begin
        if (is_read_i) tx_d = rbuf_i;
        else           oe_d = 1'b0;
      end else if (cnt_i > SLOT_STAT) begin
        tx_d = {tx_q[BYTE_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= '0;
      oe_q <= 1'b0;
    end else begin
      tx_q <= tx_d;
      oe_q <= oe_d;
    end
  end

  assign miso_o = oe_q & tx_q[BYTE_W-1];
  assign oe_o   = oe_q;
endmodule

// File: rtl/smap_top.sv
module smap_top
  import smap_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_csn,
  input  logic              spi_sclk,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  input  logic [7:0]        status_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  input  logic [7:0]        mem_rdata,
  output logic [7:0]        cmd_reg,
  output logic              irq
);
  logic             rst_sync_n, rise, fall, cs_end, cmd_done;
  logic [CNT_W-1:0] cnt;
  byte_t            cmd, rbuf, creg_q, creg_d;
  logic             irq_q, irq_d;

  smap_rst_sync i_rst (.clk(clk), .rst_ni(rst_n), .rst_sync_no(rst_sync_n));

  smap_edge i_edge (
    .clk(clk), .rst_ni(rst_sync_n), .sclk_i(spi_sclk), .csn_i(spi_csn),
    .sclk_rise_o(rise), .sclk_fall_o(fall), .cs_end_o(cs_end)
  );

  smap_frame #(.ADDR_W(ADDR_W)) i_frame (
    .clk(clk), .rst_ni(rst_sync_n), .csn_i(spi_csn), .rise_i(rise),
    .fall_i(fall), .mosi_i(spi_mosi), .mem_rdata_i(mem_rdata),
    .cnt_o(cnt), .cmd_o(cmd), .cmd_done_o(cmd_done), .rbuf_o(rbuf),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_we_o(mem_we), .mem_re_o(mem_re)
  );

  smap_tx i_tx (
    .clk(clk), .rst_ni(rst_sync_n), .csn_i(spi_csn), .fall_i(fall),
    .cnt_i(cnt), .is_read_i(cmd[BYTE_W-1]), .status_i(status_in),
    .rbuf_i(rbuf), .miso_o(spi_miso), .oe_o(spi_miso_oe)
  );

  always_comb begin
    creg_d = creg_q;
    irq_d  = 1'b0;
    if (cs_end && cmd_done && (cmd[BYTE_W-2:0] != '0)) begin
      creg_d = cmd;
      irq_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      creg_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      creg_q <= creg_d;
      irq_q  <= irq_d;
    end
  end

  assign cmd_reg = creg_q;
  assign irq     = irq_q;

  a_r7_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq |=> !irq);
  a_r8_irq_not_idle: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq |-> (cmd_reg[BYTE_W-2:0] != '0));
  a_r7_creg_with_irq: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$stable(cmd_reg) |-> irq);
  a_r6_oe_off_idle: assert property (@(posedge clk) disable iff (!rst_sync_n)
    spi_csn |=> !spi_miso_oe);
  a_r6_oe_slot: assert property (@(posedge clk) disable iff (!rst_sync_n)
    spi_miso_oe |-> (cnt >= SLOT_STAT));
endmodule

// File: tb/test_smap_top.sv
module test_smap_top;
  localparam int CLK_P = 10;
  localparam int HALF  = 4;
  localparam int AW    = 8;

  logic          clk = 1'b0;
  logic          rst_n, spi_csn, spi_sclk, spi_mosi;
  logic          spi_miso, spi_miso_oe, mem_we, mem_re, irq;
  logic [7:0]    status_in, mem_wdata, cmd_reg;
  logic [7:0]    mem_rdata;
  logic [AW-1:0] mem_addr;

  logic [7:0] mem   [256];
  logic [7:0] model [256];
  logic [7:0] wq [$];
  logic [7:0] exp_creg;
  int vectors = 0, fails = 0, irq_cnt = 0;
  logic csn_prev = 1'b1;
  logic mon_on = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  smap_top #(.ADDR_W(AW)) i_smap_top (
    .clk(clk), .rst_n(rst_n), .spi_csn(spi_csn), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .status_in(status_in), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata),
    .cmd_reg(cmd_reg), .irq(irq)
  );

  // behavioural memory with one cycle of read latency
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 7 + 3);
      mem_rdata <= 8'h00;
    end else begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      if (mem_re) mem_rdata <= mem[mem_addr];
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // per-clock monitor
  always @(negedge clk) begin
    if (mon_on) begin
      if (irq) irq_cnt++;
      check(!(mem_we && mem_re), "R10", "strobes both high", {mem_we, mem_re}, 0);
      if (csn_prev && spi_csn)
        check(spi_miso_oe == 1'b0, "R6", "oe while deselected", spi_miso_oe, 0);
    end
    csn_prev <= spi_csn;
  end

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  task automatic run_frame(input logic [15:0] a, input logic [7:0] c,
                           input logic [7:0] st, input int nbits, input string tag);
    bit rd;
    logic [7:0] aw;
    int nfull, bad;
    rd = c[7];
    aw = a[7:0];
    status_in = st;
    irq_cnt = 0;
    @(negedge clk) spi_csn = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      logic b, exp_oe, exp_bit;
      int k, bi;
      k  = (i - 32) / 8;
      bi = 7 - ((i - 32) % 8);
      if (i < 16)      b = a[15 - i];
      else if (i < 24) b = c[23 - i];
      else if (i < 32) b = 1'b0;
      else             b = rd ? 1'b0 : wq[k][bi];
      spi_mosi = b;
      repeat (HALF) @(negedge clk);
      if (i < 24)      begin exp_oe = 1'b0; exp_bit = 1'b0; end
      else if (i < 32) begin exp_oe = 1'b1; exp_bit = st[31 - i]; end
      else if (rd)     begin exp_oe = 1'b1; exp_bit = model[8'(aw + k)][bi]; end
      else             begin exp_oe = 1'b0; exp_bit = 1'b0; end
      check(spi_miso_oe == exp_oe, (i < 32) ? "R6" : "R6", $sformatf("%s oe slot %0d", tag, i),
            spi_miso_oe, exp_oe);
      if (exp_oe)
        check(spi_miso == exp_bit, (i < 32) ? "R3" : "R4",
              $sformatf("%s miso slot %0d", tag, i), spi_miso, exp_bit);
      spi_sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      spi_sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    spi_csn = 1'b1;
    repeat (6) @(negedge clk);
    // R7 / R8 / R9 expectations at frame end
    if (nbits >= 24 && c[6:0] != 7'd0) begin
      check(irq_cnt == 1, "R7", {tag, " irq pulses"}, irq_cnt, 1);
      exp_creg = c;
    end else begin
      check(irq_cnt == 0, (nbits < 24) ? "R9" : "R8", {tag, " irq pulses"}, irq_cnt, 0);
    end
    check(cmd_reg == exp_creg, (nbits < 24) ? "R9" : "R8", {tag, " cmd_reg"}, cmd_reg, exp_creg);
    if (!rd && nbits >= 32) begin
      nfull = (nbits - 32) / 8;
      for (int k = 0; k < nfull; k++) model[8'(aw + k)] = wq[k];
    end
    bad = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== model[i]) bad++;
    check(bad == 0, "R5", {tag, " memory image mismatching bytes"}, bad, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) model[i] = 8'(i * 7 + 3);
    exp_creg  = 8'h00;
    rst_n     = 1'b0;
    spi_csn   = 1'b1;
    spi_sclk  = 1'b0;
    spi_mosi  = 1'b0;
    status_in = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11 reset state
    check(irq == 1'b0, "R11", "irq after reset", irq, 0);
    check(cmd_reg == 8'h00, "R11", "cmd_reg after reset", cmd_reg, 0);
    check(spi_miso_oe == 1'b0, "R11", "oe after reset", spi_miso_oe, 0);
    check(!mem_we && !mem_re, "R11", "strobes after reset", {mem_we, mem_re}, 0);
    mon_on = 1'b1;

    // R5 R7: write burst of three bytes
    wq = '{8'hDE, 8'hAD, 8'hBE};
    run_frame(16'h0010, 8'h05, 8'h3C, 56, "write burst");
    // R1 R2 R3 R4: read back with upper address bits set
    run_frame(16'hA710, 8'h85, 8'hA5, 56, "read burst");
    // R4 R8: idle read code wrapping past the top of memory
    run_frame(16'h12FE, 8'h80, 8'h5A, 64, "idle read wrap");
    // R8: idle write code still writes
    wq = '{8'h11, 8'h22};
    run_frame(16'h0040, 8'h00, 8'hC3, 48, "idle write");
    run_frame(16'h0040, 8'hC1, 8'h0F, 48, "read idle-written");
    // R5 R9: write wrapping, cut three bits into the third byte
    wq = '{8'h9A, 8'h7B, 8'hFF};
    run_frame(16'h00FF, 8'h11, 8'h81, 51, "partial write");
    run_frame(16'h00FF, 8'h91, 8'h66, 56, "read partial");
    // R9: abort inside the command
    wq = '{8'h00};
    run_frame(16'h0030, 8'h22, 8'h00, 20, "abort in command");
    // R7 R9: abort inside the status byte after a full command
    run_frame(16'h0030, 8'h33, 8'hF0, 30, "abort in status");
    finish_run();
  end
endmodule